// File: doc/BRIEF.md
# Serial Configuration Port for a Two-Channel Sensor Signal Processor

This block is the digital control front end of a two-channel sensor conditioning chain. A host writes 8-bit command words over a four-wire serial bus, and the block keeps the resulting settings as plain control codes: which sensor channel is routed through, the gain step, the bandpass centre step, the integrator time-constant step, and a prescaler word. The prescaler word holds a divider code, which selects the reference clock frequency, and an output-disable bit for the serial data output. The analog stages themselves sit outside the block and only read these codes.

All bus pins are oversampled by the block's own clock through two-stage synchronizers, and edges are found by comparing successive synchronized samples. A word takes effect only when chip select returns high after exactly eight data bits. While the host holds chip select low, the serial output shifts out the last complete word received, so the host can read back what it wrote. The output enable obeys a fixed priority: an active-low diagnostic input forces the output on, the output-disable bit forces it off, and otherwise it follows chip select. A level input that selects integrate or hold is synchronized and passed on, together with a one-cycle strobe when hold mode begins.

Top module: `sigproc_cfg_port`

## Requirements
- R1: Data bits are taken from `spi_sdi` on each falling edge of `spi_sck` while `spi_cs_n` is low, first bit into the most significant position. The word is applied when `spi_cs_n` rises.
- R2: A word is applied only if exactly eight falling clock edges occurred while selected. A frame with fewer or more edges changes no setting and does not change the echoed word.
- R3: The target is decoded from the top bits of the word. `00` sets the bandpass code to bits 5..0. `01` sets the gain code to bits 5..0. `10` sets the integrator code to bits 4..0, and bit 5 is ignored. `110` sets the divider code to bits 4..1 and the output-disable bit to bit 0. `111` sets the channel select to bit 0.
- R4: `spi_sdo_en` is low whenever `spi_cs_n` is high and the diagnostic input is inactive.
- R5: When the output-disable bit is 1, `spi_sdo_en` stays low even while `spi_cs_n` is low. Writing 0 to it makes the output active again during selection.
- R6: While `test_n` is low, `spi_sdo_en` is high regardless of `spi_cs_n` and of the output-disable bit.
- R7: During a selected frame, `spi_sdo` presents the last word applied or rejected after a full 8-bit frame, most significant bit first. The first bit is valid from the chip-select fall, and the output advances one bit on each rising `spi_sck` edge after the first falling edge.
- R8: `ref_mhz` gives the reference frequency for divider codes 0 to 8, in order: 4, 5, 6, 8, 10, 12, 16, 20, 24 MHz.
- R9: A prescaler word whose divider code is 9 to 15 is discarded as a whole, so the divider code and the output-disable bit keep their values.
- R10: After reset, all codes, the channel select and the output-disable bit are 0, `ref_mhz` is 4, and `spi_sdo`, `spi_sdo_en`, `integ_active` and `hold_strobe` are 0.
- R11: `integ_active` follows `int_hold_in`, with high meaning integrate. `hold_strobe` pulses for one cycle when integrate changes to hold.
- R12: `spi_sck` edges while `spi_cs_n` is high have no effect on the settings or on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the bus pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sdi | input | 1 | Serial data in |
| test_n | input | 1 | Diagnostic mode request, active low |
| int_hold_in | input | 1 | High selects integrate, low selects hold |
| spi_sdo | output | 1 | Serial data out (echo) |
| spi_sdo_en | output | 1 | Drive enable for the serial data output |
| chan_sel | output | 1 | Sensor channel select |
| gain_code | output | 6 | Gain step |
| band_code | output | 6 | Bandpass centre step |
| integ_code | output | 5 | Integrator time-constant step |
| div_code | output | 4 | Reference divider code |
| ref_mhz | output | 5 | Reference frequency in MHz for the divider code |
| integ_active | output | 1 | Synchronized integrate mode |
| hold_strobe | output | 1 | One-cycle pulse on entry into hold mode |

## Verification
Each bus pin passes two synchronizer flops and one edge register, so an edge driven between clock edges takes effect on the third rising clock edge after it. Settings and the echo shifter therefore change at that edge, while `spi_sdo_en`, `integ_active` and `hold_strobe` follow one edge earlier. The bench keeps a behavioural pin history with these depths and derives every expected output from it, then compares on the falling clock edge of every cycle. It also drives its frames with half-periods of eight clocks and makes the explicit checks well after each of these windows has closed.

// File: rtl/sigproc_cfg_pkg.sv
package sigproc_cfg_pkg;

    localparam int WORD_W    = 8;
    localparam int GAIN_W    = 6;
    localparam int BAND_W    = 6;
    localparam int INTEG_W   = 5;
    localparam int DIV_W     = 4;
    localparam int MHZ_W     = 5;
    localparam int DIV_CODES = 9;
    localparam int CNT_MAX   = WORD_W + 1;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    localparam int ADDR_HI   = WORD_W - 1;
    localparam int ADDR_MID  = WORD_W - 2;
    localparam int ADDR_LO   = WORD_W - 3;

    typedef enum logic [2:0] {
        DST_BAND,
        DST_GAIN,
        DST_INTEG,
        DST_PRESC,
        DST_CHAN
    } dest_e;

    typedef struct packed {
        logic               chan;
        logic [GAIN_W-1:0]  gain;
        logic [BAND_W-1:0]  band;
        logic [INTEG_W-1:0] integ;
        logic [DIV_W-1:0]   div;
        logic               out_off;
    } cfg_t;

    function automatic dest_e dest_of(input logic [WORD_W-1:0] w);
        dest_e d;
        if (!w[ADDR_HI])       d = w[ADDR_MID] ? DST_GAIN : DST_BAND;
        else if (!w[ADDR_MID]) d = DST_INTEG;
        else if (!w[ADDR_LO])  d = DST_PRESC;
        else                   d = DST_CHAN;
        return d;
    endfunction

    function automatic logic div_ok(input logic [DIV_W-1:0] c);
        return int'(c) < DIV_CODES;
    endfunction

    function automatic logic [MHZ_W-1:0] ref_mhz_of(input logic [DIV_W-1:0] c);
        logic [MHZ_W-1:0] f;
        case (c)
            4'd0:    f = 5'd4;
            4'd1:    f = 5'd5;
            4'd2:    f = 5'd6;
            4'd3:    f = 5'd8;
            4'd4:    f = 5'd10;
            4'd5:    f = 5'd12;
            4'd6:    f = 5'd16;
            4'd7:    f = 5'd20;
            4'd8:    f = 5'd24;
            default: f = 5'd4;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/sigproc_cfg_sync.sv
module sigproc_cfg_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic s1_q, s2_q, s3_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= RST_VAL[g];
                s2_q <= RST_VAL[g];
                s3_q <= RST_VAL[g];
            end else begin
                s1_q <= pin_i[g];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end

        assign cur_o[g]  = s2_q;
        assign prev_o[g] = s3_q;
    end

endmodule

// File: rtl/sigproc_cfg_shifter.sv
module sigproc_cfg_shifter
    import sigproc_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_cur,
    input  logic              cs_prev,
    input  logic              sck_cur,
    input  logic              sck_prev,
    input  logic              sdi_cur,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o,
    output logic              sdo_o
);

    logic [WORD_W-1:0] rx_q, tx_q, echo_q;
    logic [CNT_W-1:0]  cnt_q;
    logic cs_fall, cs_rise, sck_rise, sck_fall, full_word;

    assign cs_fall   = !cs_cur && cs_prev;
    assign cs_rise   = cs_cur && !cs_prev;
    assign sck_rise  = sck_cur && !sck_prev;
    assign sck_fall  = !sck_cur && sck_prev;
    assign full_word = (cnt_q == CNT_W'(WORD_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q   <= '0;
            tx_q   <= '0;
            echo_q <= '0;
            cnt_q  <= '0;
        end else if (cs_fall) begin
            tx_q  <= echo_q;
            cnt_q <= '0;
        end else if (cs_rise) begin
            if (full_word) echo_q <= rx_q;
        end else if (!cs_cur) begin
            if (sck_rise && cnt_q != '0)
                tx_q <= {tx_q[WORD_W-2:0], 1'b0};
            if (sck_fall) begin
                rx_q <= {rx_q[WORD_W-2:0], sdi_cur};
                if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign word_vld_o = cs_rise && full_word;
    assign word_o     = rx_q;
    assign sdo_o      = tx_q[WORD_W-1];

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= CNT_MAX);

    // R12
    idle_rx_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_cur && cs_prev) |=> $stable(rx_q));

endmodule

// File: rtl/sigproc_cfg_regs.sv
module sigproc_cfg_regs
    import sigproc_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output cfg_t              cfg_o,
    output logic [MHZ_W-1:0]  ref_mhz_o
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (dest_of(wr_word))
                DST_BAND:  cfg_q.band  <= wr_word[BAND_W-1:0];
                DST_GAIN:  cfg_q.gain  <= wr_word[GAIN_W-1:0];
                DST_INTEG: cfg_q.integ <= wr_word[INTEG_W-1:0];
                DST_PRESC: begin
                    if (div_ok(wr_word[DIV_W:1])) begin
                        cfg_q.div     <= wr_word[DIV_W:1];
                        cfg_q.out_off <= wr_word[0];
                    end
                end
                DST_CHAN:  cfg_q.chan  <= wr_word[0];
                default:   cfg_q       <= cfg_q;
            endcase
        end
    end

    assign cfg_o     = cfg_q;
    assign ref_mhz_o = ref_mhz_of(cfg_q.div);

    // R2
    no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_q));

    // R9
    div_legal_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cfg_q.div) < DIV_CODES);

endmodule

// File: rtl/sigproc_cfg_port.sv
module sigproc_cfg_port
    import sigproc_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               spi_sck,
    input  logic               spi_cs_n,
    input  logic               spi_sdi,
    input  logic               test_n,
    input  logic               int_hold_in,
    output logic               spi_sdo,
    output logic               spi_sdo_en,
    output logic               chan_sel,
    output logic [GAIN_W-1:0]  gain_code,
    output logic [BAND_W-1:0]  band_code,
    output logic [INTEG_W-1:0] integ_code,
    output logic [DIV_W-1:0]   div_code,
    output logic [MHZ_W-1:0]   ref_mhz,
    output logic               integ_active,
    output logic               hold_strobe
);

    localparam int PIN_N  = 5;
    localparam int P_CS   = 4;
    localparam int P_SCK  = 3;
    localparam int P_SDI  = 2;
    localparam int P_TST  = 1;
    localparam int P_IH   = 0;
    localparam logic [PIN_N-1:0] PIN_IDLE = 5'b10010;

    logic [PIN_N-1:0] pin_raw, pin_cur, pin_prev;
    logic             word_vld;
    logic [WORD_W-1:0] word;
    logic             diag;
    cfg_t             cfg;

    assign pin_raw = {spi_cs_n, spi_sck, spi_sdi, test_n, int_hold_in};

    sigproc_cfg_sync #(.W(PIN_N), .RST_VAL(PIN_IDLE)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_raw),
        .cur_o  (pin_cur),
        .prev_o (pin_prev)
    );

    sigproc_cfg_shifter shift_i (
        .clk        (clk),
        .rst        (rst),
        .cs_cur     (pin_cur[P_CS]),
        .cs_prev    (pin_prev[P_CS]),
        .sck_cur    (pin_cur[P_SCK]),
        .sck_prev   (pin_prev[P_SCK]),
        .sdi_cur    (pin_cur[P_SDI]),
        .word_vld_o (word_vld),
        .word_o     (word),
        .sdo_o      (spi_sdo)
    );

    sigproc_cfg_regs regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (word_vld),
        .wr_word   (word),
        .cfg_o     (cfg),
        .ref_mhz_o (ref_mhz)
    );

    // Output enable priority: diagnostic, then disable bit, then select.
    assign diag       = !pin_cur[P_TST];
    assign spi_sdo_en = diag || (!pin_cur[P_CS] && !cfg.out_off);

    assign chan_sel   = cfg.chan;
    assign gain_code  = cfg.gain;
    assign band_code  = cfg.band;
    assign integ_code = cfg.integ;
    assign div_code   = cfg.div;

    assign integ_active = pin_cur[P_IH];
    assign hold_strobe  = pin_prev[P_IH] && !pin_cur[P_IH];

    // R4
    deselect_off_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_cur[P_CS] && pin_cur[P_TST]) |-> !spi_sdo_en);

    // R5
    disable_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.out_off && pin_cur[P_TST]) |-> !spi_sdo_en);

    // R6
    diag_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !pin_cur[P_TST] |-> spi_sdo_en);

    // R11
    hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
        hold_strobe |-> ($past(integ_active) && !integ_active));

endmodule

// File: tb/sigproc_cfg_port_tb_top.sv
module sigproc_cfg_port_tb_top;

    localparam int HALF = 8;
    localparam int GAP  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_sdi = 1'b0;
    logic test_n = 1'b1, int_hold_in = 1'b0;
    logic spi_sdo, spi_sdo_en, chan_sel, integ_active, hold_strobe;
    logic [5:0] gain_code, band_code;
    logic [4:0] integ_code, ref_mhz;
    logic [3:0] div_code;

    int checks = 0;
    int errors = 0;

    sigproc_cfg_port dut_i (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_sdi(spi_sdi), .test_n(test_n), .int_hold_in(int_hold_in),
        .spi_sdo(spi_sdo), .spi_sdo_en(spi_sdo_en), .chan_sel(chan_sel),
        .gain_code(gain_code), .band_code(band_code), .integ_code(integ_code),
        .div_code(div_code), .ref_mhz(ref_mhz), .integ_active(integ_active),
        .hold_strobe(hold_strobe)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int mhz_ref(input int c);
        int t [9] = '{4, 5, 6, 8, 10, 12, 16, 20, 24};
        return t[c];
    endfunction

    // Behavioural reference: pin history {cs, sck, sdi, test, ih}
    logic [4:0] h [4];
    logic       m_chan, m_off;
    logic [5:0] m_gain, m_band;
    logic [4:0] m_integ;
    logic [3:0] m_div;
    logic [7:0] m_rx, m_tx, m_echo;
    int         m_cnt;

    task automatic m_apply(input logic [7:0] w);
        if (w[7:6] == 2'b00)      m_band = w[5:0];
        else if (w[7:6] == 2'b01) m_gain = w[5:0];
        else if (w[7:6] == 2'b10) m_integ = w[4:0];
        else if (!w[5]) begin
            if (w[4:1] < 4'd9) begin
                m_div = w[4:1];
                m_off = w[0];
            end
        end else m_chan = w[0];
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) h[i] = 5'b10010;
            m_chan = 0; m_off = 0; m_gain = 0; m_band = 0; m_integ = 0;
            m_div = 0; m_rx = 0; m_tx = 0; m_echo = 0; m_cnt = 0;
        end else begin
            for (int i = 3; i > 0; i--) h[i] = h[i-1];
            h[0] = {spi_cs_n, spi_sck, spi_sdi, test_n, int_hold_in};
            if (!h[2][4] && h[3][4]) begin
                m_tx = m_echo;
                m_cnt = 0;
            end else if (h[2][4] && !h[3][4]) begin
                if (m_cnt == 8) begin
                    m_echo = m_rx;
                    m_apply(m_rx);
                end
            end else if (!h[2][4]) begin
                if (h[2][3] && !h[3][3]) begin
                    if (m_cnt != 0) m_tx = {m_tx[6:0], 1'b0};
                end else if (!h[2][3] && h[3][3]) begin
                    m_rx = {m_rx[6:0], h[2][2]};
                    if (m_cnt < 9) m_cnt++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(int'(chan_sel),   int'(m_chan),  "R3 channel (per cycle)");
            chk(int'(gain_code),  int'(m_gain),  "R3 gain (per cycle)");
            chk(int'(band_code),  int'(m_band),  "R3 bandpass (per cycle)");
            chk(int'(integ_code), int'(m_integ), "R3 integrator (per cycle)");
            chk(int'(div_code),   int'(m_div),   "R9 divider (per cycle)");
            chk(int'(ref_mhz),    mhz_ref(int'(m_div)), "R8 frequency (per cycle)");
            chk(int'(spi_sdo),    int'(m_tx[7]), "R7 serial data (per cycle)");
            chk(int'(spi_sdo_en),
                int'(!h[1][1] || (!h[1][4] && !m_off)), "R4 R5 R6 enable (per cycle)");
            chk(int'(integ_active), int'(h[1][0]), "R11 integrate (per cycle)");
            chk(int'(hold_strobe),  int'(h[2][0] && !h[1][0]), "R11 strobe (per cycle)");
        end
    end

    logic [7:0] last_full = 8'h00;

    task automatic frame(input logic [7:0] w, input int nbits);
        logic [7:0] seen = 8'h00;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_sdi = (i < 8) ? w[7-i] : 1'b0;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            if (i < 8) seen[7-i] = spi_sdo;
            spi_sck = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        spi_cs_n = 1'b1;
        repeat (GAP) @(negedge clk);
        if (nbits == 8) begin
            chk(int'(seen), int'(last_full), "R7 echo of previous word");
            last_full = w;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(int'(gain_code), 0, "R10 gain after reset");
        chk(int'(band_code), 0, "R10 bandpass after reset");
        chk(int'(integ_code), 0, "R10 integrator after reset");
        chk(int'(chan_sel), 0, "R10 channel after reset");
        chk(int'(div_code), 0, "R10 divider after reset");
        chk(int'(ref_mhz), 4, "R10 frequency after reset");
        chk(int'(spi_sdo_en), 0, "R10 enable after reset");
        chk(int'(spi_sdo), 0, "R10 data after reset");

        // R1 R3 field decoding
        frame(8'h6A, 8);
        chk(int'(gain_code), 42, "R1 R3 gain word");
        frame(8'h15, 8);
        chk(int'(band_code), 21, "R3 bandpass word");
        frame(8'hBF, 8);
        chk(int'(integ_code), 31, "R3 integrator word bit5 ignored");
        frame(8'hA3, 8);
        chk(int'(integ_code), 3, "R3 integrator word");
        frame(8'hE1, 8);
        chk(int'(chan_sel), 1, "R3 channel word");
        chk(int'(gain_code), 42, "R3 gain kept by other targets");
        frame(8'hE0, 8);
        chk(int'(chan_sel), 0, "R3 channel back to zero");

        // R8 every divider code
        for (int c = 0; c < 9; c++) begin
            frame({3'b110, 4'(c), 1'b0}, 8);
            chk(int'(div_code), c, "R8 divider code");
            chk(int'(ref_mhz), mhz_ref(c), "R8 frequency");
        end
        frame(8'hCA, 8);
        chk(int'(ref_mhz), 12, "R8 code 5");

        // R9 illegal divider codes
        frame({3'b110, 4'd11, 1'b1}, 8);
        chk(int'(div_code), 5, "R9 illegal code keeps divider");
        frame({3'b110, 4'd15, 1'b1}, 8);
        chk(int'(div_code), 5, "R9 illegal code keeps divider");
        chk(int'(spi_sdo_en), 0, "R9 disable bit not taken");

        // R2 partial and long frames
        frame(8'h41, 5);
        chk(int'(gain_code), 42, "R2 short frame discarded");
        frame(8'h41, 9);
        chk(int'(gain_code), 42, "R2 long frame discarded");
        frame(8'h7F, 8);
        chk(int'(gain_code), 63, "R2 full frame after partial");

        // R12 clock toggles while deselected
        for (int i = 0; i < 3; i++) begin
            spi_sdi = 1'b1;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        chk(int'(gain_code), 63, "R12 idle clocks ignored");
        chk(int'(spi_sdo_en), 0, "R12 R4 output off while deselected");
        frame(8'h05, 8);
        chk(int'(band_code), 5, "R12 next frame unaffected");

        // R4 R5 output enable
        spi_cs_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(int'(spi_sdo_en), 1, "R4 enabled while selected");
        spi_cs_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(int'(spi_sdo_en), 0, "R4 disabled when deselected");
        frame(8'hC1, 8);
        spi_cs_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(int'(spi_sdo_en), 0, "R5 disable bit overrides select");
        spi_cs_n = 1'b1;
        repeat (GAP) @(negedge clk);

        // R6 diagnostic mode
        test_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(int'(spi_sdo_en), 1, "R6 diagnostic drives output");
        frame(8'h3C, 8);
        chk(int'(spi_sdo_en), 1, "R6 diagnostic overrides disable bit");
        chk(int'(band_code), 60, "R6 words accepted in diagnostic");
        test_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(int'(spi_sdo_en), 0, "R6 diagnostic released");

        frame(8'hC0, 8);
        spi_cs_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(int'(spi_sdo_en), 1, "R5 clearing disable bit re-enables");
        spi_cs_n = 1'b1;
        repeat (GAP) @(negedge clk);

        // R11 integrate and hold
        int_hold_in = 1'b1;
        repeat (6) @(negedge clk);
        chk(int'(integ_active), 1, "R11 integrate mode");
        begin
            int pulses = 0;
            int_hold_in = 1'b0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (hold_strobe) pulses++;
            end
            chk(pulses, 1, "R11 single hold strobe");
        end
        chk(int'(integ_active), 0, "R11 hold mode");

        // R7 echo of an illegal prescaler word still returned
        frame({3'b110, 4'd12, 1'b0}, 8);
        frame(8'h00, 8);
        chk(int'(band_code), 0, "R3 bandpass cleared");

        repeat (10) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule